// File: doc/BRIEF.md
# Keyed-Write Watchdog Timer

This block is a watchdog timer built around an 8-bit up-counter. The counter advances once per prescaled tick. A 3-bit divider code chooses the tick period, from one tick every 32 clocks up to one tick every 4096 clocks. Software reaches the counter and a control register through a 16-bit write bus with a one-bit register select. The upper byte of every write must carry the key that belongs to the addressed register. A write with any other upper byte is dropped without effect, so a stray store cannot disturb the timer.

When the counter rolls over from 0xFF to 0x00, the block sets a sticky overflow flag in the control register. It also raises a single-cycle request output, which the surrounding logic may use as a reset or interrupt source. To keep the system alive, software reloads the counter with a keyed write before it wraps. That reload also restarts the prescaler, so the next tick is a full period away. Reads return the plain 8-bit register contents.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the counter reads 0x00, the control register reads 0x00 (timer stopped, divider code 0, flag clear), and the request output is low.
- R2: A write with `wrSel`=0 and upper byte 0x5A loads the lower byte into the counter at the next edge, and restarts the prescaler from zero.
- R3: A write with `wrSel`=1 and upper byte 0xA5 loads the control register: bit 7 is the timer enable, bit 5 is the overflow flag, and bits [2:0] are the divider code. Bits 6, 4 and 3 always read 0.
- R4: A write whose upper byte differs from the key of the addressed register leaves both registers unchanged. This includes a write that uses the other register's key.
- R5: While the timer is enabled with divider code n, the counter increments once every 32·2^n clocks. The first increment comes 32·2^n clocks after a counter write.
- R6: While bit 7 is clear, neither the counter nor the prescaler advances. When the timer is enabled again, the prescaler resumes from the phase it held.
- R7: A wrap from 0xFF to 0x00 sets bit 5. In the cycle in which the counter first reads 0x00, `reqPulse` is high for exactly that one cycle.
- R8: The flag stays set until a keyed control write with bit 5 = 0. If that write falls on the same edge as a wrap, the flag remains set.
- R9: A keyed counter write on the same edge as a tick takes priority. The counter takes the written value, and no wrap or request occurs.
- R10: `rdData` shows the counter when `rdSel`=0 and the control register when `rdSel`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe, one cycle per write |
| wrSel | input | 1 | Write target: 0 counter, 1 control |
| wrData | input | 16 | Key byte in [15:8], value in [7:0] |
| rdSel | input | 1 | Read target: 0 counter, 1 control |
| rdData | output | 8 | Selected register value |
| reqPulse | output | 1 | One-cycle overflow request |

## Verification
Two pairs of events can land on the same clock edge: a flag-clearing control write with a wrap, and a counter reload with a tick. The bench provokes each pair by loading the counter with 0xFF, waiting exactly 31 idle clocks with divider code 0, and issuing the write on the 32nd edge. In the first case the flag must read 1 and the request must fire. In the second case the counter must hold the written value, with no request and no flag change. A behavioural model tracks phase and count on every clock, so any disagreement in the cycles around these edges is also reported.

// File: rtl/keyed_watchdog_pkg.sv
package keyed_watchdog_pkg;
  localparam int CNT_W      = 8;
  localparam int BUS_W      = 16;
  localparam int CKS_W      = 3;
  localparam int BASE_SHIFT = 5;                       // code 0 -> 1/32
  localparam int NSEL       = 1 << CKS_W;
  localparam int PRE_W      = BASE_SHIFT + NSEL - 1;   // widest divider
  localparam logic [7:0] KEY_CNT = 8'h5A;
  localparam logic [7:0] KEY_CTL = 8'hA5;
  localparam int EN_BIT     = 7;
  localparam int FLAG_BIT   = 5;

  typedef struct packed {
    logic             run;
    logic             load;
    logic [CNT_W-1:0] loadVal;
    logic [CKS_W-1:0] cks;
  } strobe_t;
endpackage

// File: rtl/keyed_watchdog_ctrl.sv
module keyed_watchdog_ctrl
  import keyed_watchdog_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             wrSel,
  input  logic [BUS_W-1:0] wrData,
  input  logic             wrapEvent,
  output strobe_t          strobes,
  output logic [CNT_W-1:0] ctrlVal,
  output logic             reqPulse
);
  logic             enReg;
  logic             flagReg;
  logic [CKS_W-1:0] cksReg;
  logic             cntKeyOk;
  logic             ctlKeyOk;
  logic [7:0]       keyByte;
  logic [CNT_W-1:0] valByte;

  assign keyByte  = wrData[BUS_W-1:CNT_W];
  assign valByte  = wrData[CNT_W-1:0];
  assign cntKeyOk = wrEn && !wrSel && (keyByte == KEY_CNT);
  assign ctlKeyOk = wrEn &&  wrSel && (keyByte == KEY_CTL);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg    <= 1'b0;
      flagReg  <= 1'b0;
      cksReg   <= '0;
      reqPulse <= 1'b0;
    end else begin
      reqPulse <= wrapEvent;
      if (ctlKeyOk) begin
        enReg   <= valByte[EN_BIT];
        cksReg  <= valByte[CKS_W-1:0];
        flagReg <= valByte[FLAG_BIT] | wrapEvent;   // overflow wins over clear
      end else if (wrapEvent) begin
        flagReg <= 1'b1;
      end
    end
  end

  always_comb begin
    strobes.run     = enReg;
    strobes.load    = cntKeyOk;
    strobes.loadVal = valByte;
    strobes.cks     = cksReg;
    ctrlVal                 = '0;
    ctrlVal[EN_BIT]         = enReg;
    ctrlVal[FLAG_BIT]       = flagReg;
    ctrlVal[CKS_W-1:0]      = cksReg;
  end
endmodule

// File: rtl/keyed_watchdog_dp.sv
module keyed_watchdog_dp
  import keyed_watchdog_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobes,
  output logic [CNT_W-1:0] cntVal,
  output logic             wrapEvent
);
  logic [PRE_W-1:0] presc;
  logic [PRE_W-1:0] limits [NSEL];
  logic             tick;

  for (genvar g = 0; g < NSEL; g++) begin : g_limit
    assign limits[g] = PRE_W'((1 << (BASE_SHIFT + g)) - 1);
  end

  assign tick      = strobes.run && (presc >= limits[strobes.cks]);
  assign wrapEvent = tick && !strobes.load && (cntVal == {CNT_W{1'b1}});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      presc  <= '0;
      cntVal <= '0;
    end else begin
      if (strobes.load)     presc <= '0;
      else if (tick)        presc <= '0;
      else if (strobes.run) presc <= presc + 1'b1;

      if (strobes.load)     cntVal <= strobes.loadVal;
      else if (tick)        cntVal <= cntVal + 1'b1;
    end
  end
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import keyed_watchdog_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        wrSel,
  input  logic [15:0] wrData,
  input  logic        rdSel,
  output logic [7:0]  rdData,
  output logic        reqPulse
);
  strobe_t          strobes;
  logic [CNT_W-1:0] cntVal;
  logic [CNT_W-1:0] ctrlVal;
  logic             wrapEvent;

  keyed_watchdog_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .wrapEvent(wrapEvent), .strobes(strobes), .ctrlVal(ctrlVal),
    .reqPulse(reqPulse)
  );

  keyed_watchdog_dp u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .cntVal(cntVal),
    .wrapEvent(wrapEvent)
  );

  assign rdData = rdSel ? ctrlVal : cntVal;
endmodule

// File: rtl/keyed_watchdog_chk.sv
module keyed_watchdog_chk (
  input logic        clk,
  input logic        rstN,
  input logic        wrEn,
  input logic        wrSel,
  input logic [15:0] wrData,
  input logic        reqPulse,
  input logic [7:0]  cntVal,
  input logic [7:0]  ctrlVal
);
  logic cntLoad;
  logic ctlLoad;
  assign cntLoad = wrEn && !wrSel && (wrData[15:8] == 8'h5A);
  assign ctlLoad = wrEn &&  wrSel && (wrData[15:8] == 8'hA5);

  assert_cnt_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    cntLoad |=> cntVal == $past(wrData[7:0]));

  assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlVal & 8'h58) == 8'h00);

  assert_bad_ctl_key_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel && !ctlLoad) |=>
      (ctrlVal[7] == $past(ctrlVal[7])) && (ctrlVal[2:0] == $past(ctrlVal[2:0])));

  assert_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    !cntLoad |=> (cntVal == $past(cntVal)) || (cntVal == $past(cntVal) + 8'd1));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlVal[7] && !cntLoad) |=> $stable(cntVal));

  assert_req_state_R7: assert property (@(posedge clk) disable iff (!rstN)
    reqPulse |-> (cntVal == 8'h00) && ctrlVal[5]);

  assert_req_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    reqPulse |=> !reqPulse);

  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlVal[5] && !ctlLoad) |=> ctrlVal[5]);
endmodule

bind keyed_watchdog keyed_watchdog_chk u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
  .reqPulse(reqPulse), .cntVal(cntVal), .ctrlVal(ctrlVal)
);

// File: tb/keyed_watchdog_test.sv
`timescale 1ns/1ps
module keyed_watchdog_test;
  logic        clk = 1'b0;
  logic        rstN;
  logic        wrEn;
  logic        wrSel;
  logic [15:0] wrData;
  logic        rdSel;
  logic [7:0]  rdData;
  logic        reqPulse;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  string curReq = "R1";

  // reference model state
  int mCnt, mPhase, mCks;
  bit mEn, mFlag, mReq;

  always #5 clk = ~clk;

  keyed_watchdog uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .rdSel(rdSel), .rdData(rdData), .reqPulse(reqPulse)
  );

  function automatic int modelCtrl();
    return (int'(mEn) << 7) | (int'(mFlag) << 5) | mCks;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic modelStep(input logic we, input logic sel, input logic [15:0] d);
    int  period;
    bit  tick, cntLd, ctlLd, wrap;
    period = 32 << mCks;
    tick   = mEn && (mPhase >= period - 1);
    cntLd  = we && !sel && (d[15:8] == 8'h5A);
    ctlLd  = we &&  sel && (d[15:8] == 8'hA5);
    wrap   = tick && !cntLd && (mCnt == 255);
    if (cntLd)      mPhase = 0;
    else if (tick)  mPhase = 0;
    else if (mEn)   mPhase = mPhase + 1;
    if (cntLd)      mCnt = int'(d[7:0]);
    else if (tick)  mCnt = (mCnt + 1) % 256;
    if (ctlLd) begin
      mEn   = d[7];
      mCks  = int'(d[2:0]);
      mFlag = d[5] | wrap;
    end else if (wrap) begin
      mFlag = 1'b1;
    end
    mReq = wrap;
  endtask

  task automatic compareAll();
    rdSel = 1'b0; #1;
    chk(curReq, int'(rdData), mCnt);
    rdSel = 1'b1; #1;
    chk(curReq, int'(rdData), modelCtrl());
    chk(curReq, int'(reqPulse), int'(mReq));
  endtask

  task automatic cycle(input logic we, input logic sel, input logic [15:0] d);
    @(negedge clk);
    wrEn = we; wrSel = sel; wrData = d;
    modelStep(we, sel, d);
    @(posedge clk); #1;
    compareAll();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cycle(1'b0, 1'b0, 16'h0000);
  endtask

  task automatic readReg(input logic sel, output int val);
    rdSel = sel; #1;
    val = int'(rdData);
  endtask

  initial begin
    int v, n;
    rstN = 1'b0; wrEn = 1'b0; wrSel = 1'b0; wrData = '0; rdSel = 1'b0;
    mCnt = 0; mPhase = 0; mCks = 0; mEn = 0; mFlag = 0; mReq = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #1;
    // R1: reset state
    curReq = "R1";
    compareAll();
    readReg(1'b0, v); chk("R1", v, 0);
    readReg(1'b1, v); chk("R1", v, 0);
    chk("R1", int'(reqPulse), 0);

    // R3: control layout, reserved bits read zero
    curReq = "R3";
    cycle(1'b1, 1'b1, 16'hA5FF);
    readReg(1'b1, v); chk("R3", v, 8'hA7);
    cycle(1'b1, 1'b1, 16'hA500);
    readReg(1'b1, v); chk("R3", v, 8'h00);

    // R4: wrong keys ignored
    curReq = "R4";
    cycle(1'b1, 1'b1, 16'h5A87);
    readReg(1'b1, v); chk("R4", v, 8'h00);
    cycle(1'b1, 1'b0, 16'hA533);
    readReg(1'b0, v); chk("R4", v, 8'h00);
    cycle(1'b1, 1'b1, 16'h0087);
    readReg(1'b1, v); chk("R4", v, 8'h00);

    // R2: keyed counter load
    curReq = "R2";
    cycle(1'b1, 1'b0, 16'h5A33);
    readReg(1'b0, v); chk("R2", v, 8'h33);

    // R5 / R7: period for every divider code
    for (int s = 0; s < 8; s++) begin
      curReq = "R5";
      cycle(1'b1, 1'b1, 16'hA580 | 16'(s));
      cycle(1'b1, 1'b0, 16'h5AFF);
      n = 0;
      do begin
        cycle(1'b0, 1'b0, 16'h0000);
        n++;
      end while (!reqPulse && n < 5000);
      chk("R5", n, 32 << s);
      curReq = "R7";
      readReg(1'b0, v); chk("R7", v, 0);
      readReg(1'b1, v); chk("R7", (v >> 5) & 1, 1);
      idle(1);
      chk("R7", int'(reqPulse), 0);
      cycle(1'b1, 1'b1, 16'hA580 | 16'(s));   // clear flag
      readReg(1'b1, v); chk("R8", (v >> 5) & 1, 0);
    end

    // R6: disable holds count and phase
    curReq = "R6";
    cycle(1'b1, 1'b1, 16'hA580);
    cycle(1'b1, 1'b0, 16'h5A40);
    idle(50);
    cycle(1'b1, 1'b1, 16'hA500);
    idle(200);
    readReg(1'b0, v); chk("R6", v, 8'h41);
    cycle(1'b1, 1'b1, 16'hA580);
    idle(12);
    readReg(1'b0, v); chk("R6", v, 8'h41);
    idle(1);
    readReg(1'b0, v); chk("R6", v, 8'h42);

    // R8: clear write on the wrap edge keeps flag
    curReq = "R8";
    cycle(1'b1, 1'b0, 16'h5AFF);
    idle(31);
    cycle(1'b1, 1'b1, 16'hA580);
    readReg(1'b1, v); chk("R8", (v >> 5) & 1, 1);
    chk("R8", int'(reqPulse), 1);
    idle(10);
    cycle(1'b1, 1'b0, 16'h5A00);
    readReg(1'b1, v); chk("R8", (v >> 5) & 1, 1);
    cycle(1'b1, 1'b1, 16'hA580);
    readReg(1'b1, v); chk("R8", (v >> 5) & 1, 0);

    // R9: counter write on a tick edge wins
    curReq = "R9";
    cycle(1'b1, 1'b0, 16'h5AFF);
    idle(31);
    cycle(1'b1, 1'b0, 16'h5A10);
    readReg(1'b0, v); chk("R9", v, 8'h10);
    chk("R9", int'(reqPulse), 0);
    readReg(1'b1, v); chk("R9", (v >> 5) & 1, 0);

    // R10: read select
    curReq = "R10";
    cycle(1'b1, 1'b1, 16'hA503);
    cycle(1'b1, 1'b0, 16'h5AC3);
    readReg(1'b0, v); chk("R10", v, 8'hC3);
    readReg(1'b1, v); chk("R10", v, 8'h03);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog (%s): actual hung expected finished", curReq);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule